// File: doc/BRIEF.md
# Serial RTC Register Pointer and Shadow

This block sits between a byte-level two-wire bus engine and the timekeeping core of a real-time clock that also carries a small battery-backed RAM. The engine reports bus events (a start in write direction, a start in read direction, a stop) and hands over received bytes or asks for the next byte to transmit. The block keeps the register pointer, holds a frozen snapshot of the seven time bytes so that one read burst sees a consistent time, and sends each written byte where it belongs: to the time core, to the control register, to user RAM, or nowhere.

The snapshot is refreshed from the live time on every start and again whenever the pointer rolls over to address 0. After a write-direction start, the first byte sets the pointer and only the bytes after it are register data. The map size and the first RAM address are parameters. A data strobe that arrives in the same cycle as a bus event is discarded. If a write strobe and a read strobe arrive together, the write is taken.

Top module: `rtc_regfile`

## Requirements
- R1: Reset clears the pointer, the snapshot, the control register, the RAM, the read data and the pointer-byte-received flag. A read issued with no start after reset returns 0x00 from address 0.
- R2: The first byte written after a write-direction start (or after a stop) loads the pointer with its low 6 bits. It writes no register and does not raise time_wr_en.
- R3: Every write-direction or read-direction start copies live_time (byte i at bits 8i+7..8i) into the snapshot. Reads of addresses 0 to 6 return the snapshot and not later changes of live_time.
- R4: Each accepted data byte, read or written, advances the pointer by one. From address MAP_SIZE-1, or from any address at or above MAP_SIZE, the next advance goes to 0.
- R5: An advance that moves the pointer to 0 copies live_time into the snapshot again.
- R6: A data byte written at address 0 to 6 raises time_wr_en in the same cycle, with time_wr_idx equal to the address and time_wr_data equal to the byte.
- R7: A data byte written at an address from RAM_BASE to MAP_SIZE-1 is stored and reads back unchanged.
- R8: A write at an address from 8 to RAM_BASE-1, or at MAP_SIZE and above, is ignored. A read at any such address returns 0x00 and still advances the pointer.
- R9: A write to the control register (address 7) stores the byte masked with 0xB3, so bits 2, 3 and 6 always read as 0.
- R10: A write cannot set control bit 5 (oscillator stopped). Writing 0 to it clears it, and writing 1 keeps its value. An osc_fail pulse sets it, and osc_fail wins over a clearing write in the same cycle.
- R11: A read-direction start leaves the pointer unchanged, so reads continue from the last pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wstart | input | 1 | Start condition, write direction (one-cycle pulse) |
| ev_rstart | input | 1 | Start condition, read direction (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition (one-cycle pulse) |
| wr_valid | input | 1 | Received byte strobe |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next byte to transmit |
| rd_data | output | 8 | Byte to transmit, valid the cycle after rd_req |
| live_time | input | 56 | Live time bytes from the time core, byte i at bits 8i+7..8i |
| osc_fail | input | 1 | Oscillator-stop detect pulse from the time core |
| time_wr_en | output | 1 | Write strobe toward the time core |
| time_wr_idx | output | 3 | Time register index of the write |
| time_wr_data | output | 8 | Time register write value |

## Verification
Two functions of this block can fall in the same cycle. A software write to the control register can clear the oscillator-stop flag while the time core raises osc_fail. A data byte at the last map address can also wrap the pointer, which recaptures the snapshot, while live_time is changing. The bench drives a clearing control write and osc_fail on the same edge and expects bit 5 set afterwards. It also changes live_time just before a read that wraps, and expects address 0 to return the new value rather than the one taken at the start. Random bursts of pointer loads, writes, reads, starts, stops and osc_fail pulses are checked byte for byte against a reference model in the bench.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

   localparam int PTR_W     = 6;           // pointer loads modulo 64
   localparam int TIME_REGS = 7;           // addresses 0..6 belong to the time core
   localparam int CTRL_ADDR = 7;
   localparam logic [7:0] CTRL_MASK = 8'hB3;
   localparam int OSF_BIT   = 5;

   typedef enum logic [1:0] {
      RGN_TIME,
      RGN_CTRL,
      RGN_RAM,
      RGN_NONE
   } region_e;

   // Classify a pointer value; all operands widened to 7 bits so that a
   // map size of 64 is representable.
   function automatic region_e classify(input logic [6:0] a,
                                        input logic [6:0] ram_base,
                                        input logic [6:0] map_size);
      if (a < 7'(TIME_REGS))                     return RGN_TIME;
      else if (a == 7'(CTRL_ADDR))               return RGN_CTRL;
      else if (a >= ram_base && a < map_size)    return RGN_RAM;
      else                                       return RGN_NONE;
   endfunction

   // Next control value: fixed-zero bits masked, oscillator-stop flag can
   // only be cleared by software and is set by the detector pulse.
   function automatic logic [7:0] ctrl_next(input logic [7:0] old,
                                            input logic [7:0] wdata,
                                            input logic       wr,
                                            input logic       osf_set);
      logic [7:0] v;
      v = wr ? (wdata & CTRL_MASK) : old;
      if (wr) v[OSF_BIT] = wdata[OSF_BIT] & old[OSF_BIT];
      if (osf_set) v[OSF_BIT] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/rtc_ptr_ctl.sv
module rtc_ptr_ctl
   import rtc_regfile_pkg::*;
#(
   parameter int MAP_SIZE = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_wstart,
   input  logic             ev_rstart,
   input  logic             ev_stop,
   input  logic             wr_valid,
   input  logic             rd_req,
   input  logic [PTR_W-1:0] ptr_byte,
   output logic [PTR_W-1:0] ptr,
   output logic             addr_seen,
   output logic             data_wr,
   output logic             rd_accept,
   output logic             wrap
);
   localparam logic [6:0] LAST = 7'(MAP_SIZE - 1);

   logic [PTR_W-1:0] ptr_q;
   logic             seen_q;
   logic             any_ev, load, advance, at_end;

   assign any_ev    = ev_wstart | ev_rstart | ev_stop;
   assign load      = ~any_ev & wr_valid & ~seen_q;
   assign data_wr   = ~any_ev & wr_valid & seen_q;
   assign rd_accept = ~any_ev & rd_req & ~wr_valid;
   assign advance   = data_wr | rd_accept;
   assign at_end    = {1'b0, ptr_q} >= LAST;
   assign wrap      = advance & at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (ev_wstart | ev_stop) seen_q <= 1'b0;
         else if (load)           seen_q <= 1'b1;

         if (load)         ptr_q <= ptr_byte;
         else if (advance) ptr_q <= at_end ? '0 : PTR_W'(ptr_q + 1'b1);
      end
   end

   assign ptr       = ptr_q;
   assign addr_seen = seen_q;
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
   import rtc_regfile_pkg::*;
#(
   parameter int NBYTES = TIME_REGS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  capture,
   input  logic [8*NBYTES-1:0]   live,
   output logic [8*NBYTES-1:0]   shadow
);
   // one register per byte lane
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)       lane_q <= 8'h00;
         else if (capture) lane_q <= live[8*i +: 8];
      end
      assign shadow[8*i +: 8] = lane_q;
   end
endmodule

// File: rtl/rtc_user_ram.sv
module rtc_user_ram
   import rtc_regfile_pkg::*;
#(
   parameter int BASE = 16,
   parameter int SIZE = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata
);
   localparam int DEPTH = SIZE - BASE;

   if (DEPTH > 0) begin : g_ram
      localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
      logic [7:0]  mem [DEPTH];
      logic [6:0]  offs;
      logic [IW-1:0] idx;
      logic        in_rng;

      assign offs   = {1'b0, addr} - 7'(BASE);
      assign in_rng = ({1'b0, addr} >= 7'(BASE)) && ({1'b0, addr} < 7'(SIZE));
      assign idx    = IW'(offs);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= 8'h00;
         end else if (wr_en && in_rng) begin
            mem[idx] <= wdata;
         end
      end

      assign rdata = in_rng ? mem[idx] : 8'h00;
   end else begin : g_noram
      assign rdata = 8'h00;
   end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_regfile_pkg::*;
#(
   parameter int MAP_SIZE = 32,
   parameter int RAM_BASE = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ev_wstart,
   input  logic                     ev_rstart,
   input  logic                     ev_stop,
   input  logic                     wr_valid,
   input  logic [7:0]               wr_data,
   input  logic                     rd_req,
   output logic [7:0]               rd_data,
   input  logic [8*TIME_REGS-1:0]   live_time,
   input  logic                     osc_fail,
   output logic                     time_wr_en,
   output logic [2:0]               time_wr_idx,
   output logic [7:0]               time_wr_data
);
   // elaboration-time parameter checks
   if (MAP_SIZE < CTRL_ADDR + 1 || MAP_SIZE > (1 << PTR_W)) begin : g_bad_map
      $error("rtc_regfile: MAP_SIZE out of range");
   end
   if (RAM_BASE < CTRL_ADDR + 1 || RAM_BASE > MAP_SIZE) begin : g_bad_base
      $error("rtc_regfile: RAM_BASE out of range");
   end

   localparam logic [6:0] BASE7 = 7'(RAM_BASE);
   localparam logic [6:0] SIZE7 = 7'(MAP_SIZE);

   logic [PTR_W-1:0]       ptr_q;
   logic                   addr_seen_q;
   logic                   data_wr, rd_accept, wrap;
   logic [8*TIME_REGS-1:0] shadow_q;
   logic [7:0]             ctrl_q;
   logic [7:0]             ram_rdata;
   logic [7:0]             rd_data_q;
   logic [7:0]             rd_mux;
   region_e                rgn;

   rtc_ptr_ctl #(.MAP_SIZE(MAP_SIZE)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_wstart (ev_wstart),
      .ev_rstart (ev_rstart),
      .ev_stop   (ev_stop),
      .wr_valid  (wr_valid),
      .rd_req    (rd_req),
      .ptr_byte  (wr_data[PTR_W-1:0]),
      .ptr       (ptr_q),
      .addr_seen (addr_seen_q),
      .data_wr   (data_wr),
      .rd_accept (rd_accept),
      .wrap      (wrap)
   );

   // snapshot refreshed on any start and on pointer roll-over
   rtc_shadow #(.NBYTES(TIME_REGS)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (ev_wstart | ev_rstart | wrap),
      .live    (live_time),
      .shadow  (shadow_q)
   );

   assign rgn = classify({1'b0, ptr_q}, BASE7, SIZE7);

   rtc_user_ram #(.BASE(RAM_BASE), .SIZE(MAP_SIZE)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (data_wr && rgn == RGN_RAM),
      .addr  (ptr_q),
      .wdata (wr_data),
      .rdata (ram_rdata)
   );

   // control register
   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= 8'h00;
      else        ctrl_q <= ctrl_next(ctrl_q, wr_data, data_wr && rgn == RGN_CTRL, osc_fail);
   end

   // time core write path (same cycle as the data strobe)
   assign time_wr_en   = data_wr && rgn == RGN_TIME;
   assign time_wr_idx  = ptr_q[2:0];
   assign time_wr_data = wr_data;

   // read multiplexer
   always_comb begin
      rd_mux = 8'h00;
      unique case (rgn)
         RGN_TIME: begin
            for (int i = 0; i < TIME_REGS; i++)
               if (ptr_q[2:0] == 3'(i)) rd_mux = shadow_q[8*i +: 8];
         end
         RGN_CTRL: rd_mux = ctrl_q;
         RGN_RAM:  rd_mux = ram_rdata;
         default:  rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         rd_data_q <= 8'h00;
      else if (rd_accept) rd_data_q <= rd_mux;
   end

   assign rd_data = rd_data_q;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
   import rtc_regfile_pkg::*;
#(
   parameter int MAP_SIZE = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   ev_wstart,
   input logic                   ev_rstart,
   input logic                   ev_stop,
   input logic                   wr_valid,
   input logic [7:0]             wr_data,
   input logic                   rd_req,
   input logic                   osc_fail,
   input logic [8*TIME_REGS-1:0] live_time,
   input logic [PTR_W-1:0]       ptr,
   input logic                   addr_seen,
   input logic [8*TIME_REGS-1:0] shadow,
   input logic [7:0]             ctrl,
   input logic                   time_wr_en
);
   localparam logic [6:0] LAST = 7'(MAP_SIZE - 1);

   logic any_ev, step;
   assign any_ev = ev_wstart | ev_rstart | ev_stop;
   assign step   = ~any_ev & ((wr_valid & addr_seen) | (rd_req & ~wr_valid));

   // R2
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ev && wr_valid && !addr_seen) |=> ptr == $past(wr_data[PTR_W-1:0]));

   // R3
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wstart || ev_rstart) |=> shadow == $past(live_time));

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && {1'b0, ptr} < LAST) |=> ptr == PTR_W'($past(ptr) + 1'b1));

   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && {1'b0, ptr} >= LAST) |=> (ptr == '0 && shadow == $past(live_time)));

   // R6
   time_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr_en |-> (wr_valid && addr_seen && {1'b0, ptr} < 7'(TIME_REGS)));

   // R9
   ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl & ~CTRL_MASK) == 8'h00);

   // R10
   osf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_fail && !ctrl[OSF_BIT]) |=> !ctrl[OSF_BIT]);

   // R11
   rstart_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rstart |=> $stable(ptr));
endmodule

bind rtc_regfile rtc_regfile_chk #(.MAP_SIZE(MAP_SIZE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev_wstart  (ev_wstart),
   .ev_rstart  (ev_rstart),
   .ev_stop    (ev_stop),
   .wr_valid   (wr_valid),
   .wr_data    (wr_data),
   .rd_req     (rd_req),
   .osc_fail   (osc_fail),
   .live_time  (live_time),
   .ptr        (ptr_q),
   .addr_seen  (addr_seen_q),
   .shadow     (shadow_q),
   .ctrl       (ctrl_q),
   .time_wr_en (time_wr_en)
);

// File: tb/sim_rtc_regfile.sv
module sim_rtc_regfile;
   localparam int MAP_SIZE = 32;
   localparam int RAM_BASE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_wstart = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic        rd_req = 1'b0;
   logic [7:0]  rd_data;
   logic [55:0] live_time = '0;
   logic        osc_fail = 1'b0;
   logic        time_wr_en;
   logic [2:0]  time_wr_idx;
   logic [7:0]  time_wr_data;

   int checks = 0;
   int failures = 0;

   // reference model state
   int         mptr;
   bit         mseen;
   logic [7:0] msh [7];
   logic [7:0] mctrl;
   logic [7:0] mram [64];

   always #2 clk = ~clk;   // 250 MHz

   rtc_regfile #(.MAP_SIZE(MAP_SIZE), .RAM_BASE(RAM_BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_wstart(ev_wstart), .ev_rstart(ev_rstart),
      .ev_stop(ev_stop), .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
      .rd_data(rd_data), .live_time(live_time), .osc_fail(osc_fail),
      .time_wr_en(time_wr_en), .time_wr_idx(time_wr_idx), .time_wr_data(time_wr_data)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input int a);
      if (a < 7) return msh[a];
      if (a == 7) return mctrl;
      if (a >= RAM_BASE && a < MAP_SIZE) return mram[a];
      return 8'h00;
   endfunction

   function automatic void capture();
      for (int i = 0; i < 7; i++) msh[i] = live_time[8*i +: 8];
   endfunction

   function automatic void advance();
      if (mptr >= MAP_SIZE - 1) begin
         mptr = 0;
         capture();
      end else mptr++;
   endfunction

   task automatic set_live(input logic [55:0] v);
      live_time = v;
   endtask

   task automatic ev_pulse(input int kind);  // 0 wstart, 1 rstart, 2 stop
      @(negedge clk);
      ev_wstart = (kind == 0);
      ev_rstart = (kind == 1);
      ev_stop   = (kind == 2);
      if (kind != 2) capture();
      if (kind != 1) mseen = 0;
      @(negedge clk);
      ev_wstart = 0; ev_rstart = 0; ev_stop = 0;
   endtask

   task automatic wr_byte(input logic [7:0] d, input bit osc);
      @(negedge clk);
      wr_valid = 1; wr_data = d; osc_fail = osc;
      #1;
      if (!mseen) begin
         chk("R2 no time write on pointer byte", {7'd0, time_wr_en}, 8'h00);
         mptr = int'(d[5:0]);
         mseen = 1;
         if (osc) mctrl[5] = 1'b1;
      end else begin
         if (mptr < 7) begin
            chk("R6 time_wr_en", {7'd0, time_wr_en}, 8'h01);
            chk("R6 time_wr_idx", {5'd0, time_wr_idx}, 8'(mptr));
            chk("R6 time_wr_data", time_wr_data, d);
         end else begin
            chk("R8 no time write", {7'd0, time_wr_en}, 8'h00);
         end
         if (mptr == 7) begin
            mctrl = {d[7], 1'b0, d[5] & mctrl[5], d[4], 2'b00, d[1:0]};
         end else if (mptr >= RAM_BASE && mptr < MAP_SIZE) begin
            mram[mptr] = d;
         end
         if (osc) mctrl[5] = 1'b1;
         advance();
      end
      @(negedge clk);
      wr_valid = 0; osc_fail = 0;
   endtask

   task automatic osc_pulse();
      @(negedge clk);
      osc_fail = 1;
      mctrl[5] = 1'b1;
      @(negedge clk);
      osc_fail = 0;
   endtask

   task automatic rd_byte(input string req);
      logic [7:0] e;
      @(negedge clk);
      rd_req = 1;
      e = exp_read(mptr);
      advance();
      @(negedge clk);
      rd_req = 0;
      chk(req, rd_data, e);
   endtask

   initial begin
      mptr = 0; mseen = 0; mctrl = 0;
      for (int i = 0; i < 7; i++) msh[i] = 0;
      for (int i = 0; i < 64; i++) mram[i] = 0;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      chk("R1 rd_data after reset", rd_data, 8'h00);
      chk("R1 time_wr_en after reset", {7'd0, time_wr_en}, 8'h00);
      set_live(56'h11_22_33_44_55_66_77);
      rd_byte("R1 snapshot cleared, pointer 0");

      // R2 + R9 + R10: pointer byte 0x47 -> address 7, write 0xFF
      ev_pulse(0);
      wr_byte(8'h47, 0);
      wr_byte(8'hFF, 0);
      ev_pulse(0); wr_byte(8'h07, 0); ev_pulse(1);
      rd_byte("R9 control masked, R10 flag not set by write");

      // R10: detector sets flag; same-cycle clearing write loses
      osc_pulse();
      ev_pulse(0); wr_byte(8'h07, 0); ev_pulse(1);
      rd_byte("R10 flag set by osc_fail");
      ev_pulse(0); wr_byte(8'h07, 0); wr_byte(8'h00, 1);
      ev_pulse(0); wr_byte(8'h07, 0); ev_pulse(1);
      rd_byte("R10 osc_fail wins over clearing write");
      ev_pulse(0); wr_byte(8'h07, 0); wr_byte(8'hFF, 0);
      ev_pulse(0); wr_byte(8'h07, 0); ev_pulse(1);
      rd_byte("R10 writing one keeps flag");
      ev_pulse(0); wr_byte(8'h07, 0); wr_byte(8'h00, 0);
      ev_pulse(0); wr_byte(8'h07, 0); ev_pulse(1);
      rd_byte("R10 writing zero clears flag");

      // R6: time writes
      ev_pulse(0); wr_byte(8'h00, 0);
      for (int i = 0; i < 7; i++) wr_byte(8'(8'h30 + i), 0);

      // R3: capture at read start, later live changes invisible
      ev_pulse(0); wr_byte(8'h00, 0);
      set_live(56'hA1_A2_A3_A4_A5_A6_A7);
      ev_pulse(1);
      set_live(56'hC1_C2_C3_C4_C5_C6_C7);
      for (int i = 0; i < 7; i++) rd_byte("R3 read from snapshot");

      // R4 + R5: wrap at last map address recaptures
      ev_pulse(0); wr_byte(8'(MAP_SIZE - 1), 0); wr_byte(8'h5C, 0);
      ev_pulse(0); wr_byte(8'(MAP_SIZE - 1), 0); ev_pulse(1);
      set_live(56'hE1_E2_E3_E4_E5_E6_E7);
      rd_byte("R4 last address");
      rd_byte("R5 recapture on wrap");

      // R8: gap region and outside the map
      ev_pulse(0); wr_byte(8'h0A, 0); wr_byte(8'h5A, 0);
      ev_pulse(0); wr_byte(8'h0A, 0); ev_pulse(1);
      rd_byte("R8 gap reads zero");
      rd_byte("R8 pointer advanced past gap");
      ev_pulse(0); wr_byte(8'h28, 0); wr_byte(8'h99, 0);
      ev_pulse(0); wr_byte(8'h28, 0); ev_pulse(1);
      set_live(56'h0F_0E_0D_0C_0B_0A_09);
      rd_byte("R8 outside map reads zero");
      rd_byte("R4 outside map returns to 0");

      // R7 + R11: RAM write then burst read across two read starts
      ev_pulse(0); wr_byte(8'd20, 0); wr_byte(8'h3C, 0); wr_byte(8'hC3, 0);
      ev_pulse(0); wr_byte(8'd20, 0); ev_pulse(1);
      rd_byte("R7 RAM readback");
      ev_pulse(1);
      rd_byte("R11 read start keeps pointer");

      // R2: stop makes next byte a pointer byte
      ev_pulse(0); wr_byte(8'd25, 0); ev_pulse(2);
      wr_byte(8'd18, 0); wr_byte(8'h77, 0);
      ev_pulse(0); wr_byte(8'd18, 0); ev_pulse(1);
      rd_byte("R2 pointer byte after stop");

      // random phase
      for (int n = 0; n < 800; n++) begin
         int op;
         op = int'($urandom_range(0, 9));
         case (op)
            0: ev_pulse(0);
            1: ev_pulse(1);
            2: ev_pulse(2);
            3: begin ev_pulse(0); wr_byte(8'($urandom), 0); end
            4, 5: wr_byte(8'($urandom), bit'($urandom_range(0, 7) == 0));
            6, 7, 8: rd_byte("R4 random read");
            default: set_live({$urandom, 24'($urandom)});
         endcase
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule